// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block drives a serial configuration flash from the master side over a four-wire link: serial clock, active-low chip select, data toward the flash and data back from it. A single start pulse erases either the whole device or one sector, picked by a 24-bit address captured at the start. The block derives the serial clock from its system clock and runs three kinds of chip-select frames in turn. The first sets the write-enable latch. The second carries the erase command. The third reads the status register and repeats until the write-in-progress bit reads 0.

Since the erase only begins when chip select rises after the command, the block never assumes the memory is ready. It polls instead, and it bounds the wait with a cycle counter that starts at the end of the erase frame. A run ends with a one-cycle done pulse. A timeout flag is raised if a poll still sees the memory busy after the configured number of system clocks. That flag stays set until the next start.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, and busy, done and timeout are all 0.
- R2: A start pulse in idle begins with an 8-bit frame carrying 8'h06, most significant bit first, before any erase frame.
- R3: With bulk=1 the erase frame is 8 bits holding 8'hC7. With bulk=0 it is 32 bits: 8'hD8 followed by the 24-bit address, both most significant bit first. Chip select rises right after the last bit.
- R4: Each status frame is 16 bits: 8'h05 is sent, then 8 status bits are read most significant bit first. Bit 0 of the status byte is write-in-progress. Polling repeats while that bit is 1, so K busy reads produce K+1 status frames.
- R5: When a status read shows bit 0 clear, done is high for exactly one cycle, busy falls in that same cycle, and timeout stays 0.
- R6: Chip select stays high for at least CS_GAP system clocks between consecutive frames.
- R7: sck is low whenever cs_n is high. mosi changes only while sck is low. Within a frame, sck rises every 2*CLK_DIV system clocks.
- R8: If a status read shows bit 0 set and at least TIMEOUT_CYCLES clocks have passed since the erase frame ended, the run ends. done pulses and timeout is set, and timeout holds until the next start.
- R9: A start pulse while busy has no effect: no extra frames follow the run's end.
- R10: bulk and addr are captured at start, and changing them later during the run does not alter the erase frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an erase run (accepted in idle only) |
| bulk | input | 1 | 1 = whole-device erase, 0 = sector erase |
| addr | input | 24 | Sector address for sector erase |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | Last run ended by timeout |

## Verification
The hardest situation to reach is the timeout. The flash must keep reporting busy across many status frames, and the run must end on the exact poll where the elapsed count first reaches the limit. The bench's flash model can hold write-in-progress at 1 forever. With a small limit, the expected poll count is ceil(TIMEOUT_CYCLES / (32*CLK_DIV + CS_GAP)). A sweep over erase kind and 0 to 3 busy reads covers normal completion. A second start pulse and changed address inputs during each run cover the ignored inputs.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int CLK_DIV        = 4,
  parameter int CS_GAP         = 4,
  parameter int TIMEOUT_CYCLES = 1_000_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        bulk,
  input  logic [23:0] addr,
  input  logic        miso,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  output logic        busy,
  output logic        done,
  output logic        timeout
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_CYCLES);

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_FRAME} st_t;
  typedef enum logic [1:0] {FR_WREN, FR_ERASE, FR_POLL} fr_t;

  st_t state;
  fr_t step;
  logic [DW-1:0] div;
  logic [GW-1:0] gap;
  logic [TW-1:0] tmo_cnt;
  logic [31:0]   tx, load;
  logic [7:0]    rx;
  logic [5:0]    nbit, flen;
  logic          bulk_q;
  logic [23:0]   addr_q;

  wire tick = (div == DW'(CLK_DIV - 1));
  assign mosi = tx[31];

  always_comb begin
    case (step)
      FR_WREN:  begin flen = 6'd8;  load = {8'h06, 24'h0}; end
      FR_ERASE: begin
        flen = bulk_q ? 6'd8 : 6'd32;
        load = bulk_q ? {8'hC7, 24'h0} : {8'hD8, addr_q};
      end
      default:  begin flen = 6'd16; load = {8'h05, 24'h0}; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; step <= FR_WREN;
      div <= '0; gap <= '0; tmo_cnt <= '0;
      tx <= '0; rx <= '0; nbit <= '0;
      bulk_q <= 1'b0; addr_q <= '0;
      sck <= 1'b0; cs_n <= 1'b1;
      busy <= 1'b0; done <= 1'b0; timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy && tmo_cnt != TMAX) tmo_cnt <= tmo_cnt + 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          busy <= 1'b1; timeout <= 1'b0;
          bulk_q <= bulk; addr_q <= addr;
          step <= FR_WREN; gap <= '0;
          state <= ST_GAP;
        end
        ST_GAP: begin
          if (gap == GW'(CS_GAP - 1)) begin
            gap <= '0; cs_n <= 1'b0; div <= '0; nbit <= '0;
            tx <= load; state <= ST_FRAME;
          end else gap <= gap + 1'b1;
        end
        default: begin
          if (!tick) div <= div + 1'b1;
          else begin
            div <= '0;
            if (!sck) begin
              sck <= 1'b1;
              rx <= {rx[6:0], miso};
              nbit <= nbit + 1'b1;
            end else begin
              sck <= 1'b0;
              if (nbit == flen) begin
                cs_n <= 1'b1;
                state <= ST_GAP;
                case (step)
                  FR_WREN:  step <= FR_ERASE;
                  FR_ERASE: begin step <= FR_POLL; tmo_cnt <= '0; end
                  default:
                    if (!rx[0] || tmo_cnt >= TMAX) begin
                      state <= ST_IDLE; busy <= 1'b0;
                      done <= 1'b1; timeout <= rx[0];
                    end
                endcase
              end else tx <= {tx[30:0], 1'b0};
            end
          end
        end
      endcase
    end
  end

  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n));
  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_tmo_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);
endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int PER = 10;
  localparam int CDIV = 2;
  localparam int GAPC = 3;
  localparam int TMO = 370;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bulk = 1'b0;
  logic [23:0] addr = '0;
  logic sck, cs_n, mosi, busy, done, timeout, miso;

  flash_erase_seq #(.CLK_DIV(CDIV), .CS_GAP(GAPC), .TIMEOUT_CYCLES(TMO)) i_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .bulk(bulk), .addr(addr), .miso(miso),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done), .timeout(timeout));

  always #(PER/2) clk = ~clk;

  int total = 0, bad = 0;
  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash model
  logic [31:0] frx = '0;
  int fbits = 0, wip_left = 0, kbusy = 0, nfr = 0;
  logic wel = 1'b0, stuck = 1'b0, erase_ok = 1'b0;
  logic [7:0] f_op [0:15];
  int f_bits [0:15];
  logic [23:0] f_addr [0:15];
  logic [7:0] stat;
  assign stat = {6'b0, wel, (stuck || wip_left > 0)};
  assign miso = (!cs_n && fbits >= 8 && fbits < 16) ? stat[15 - fbits] : 1'b0;

  always @(negedge cs_n) begin fbits = 0; frx = '0; end
  always @(posedge sck) if (!cs_n) begin frx = {frx[30:0], mosi}; fbits++; end
  always @(posedge cs_n) if (rst_n) begin
    logic [7:0] op;
    op = (fbits == 16) ? frx[15:8] : (fbits == 32) ? frx[31:24] : frx[7:0];
    if (nfr < 16) begin f_op[nfr] = op; f_bits[nfr] = fbits; f_addr[nfr] = frx[23:0]; end
    nfr++;
    if (fbits == 8 && op == 8'h06) wel = 1'b1;
    else if ((fbits == 8 && op == 8'hC7) || (fbits == 32 && op == 8'hD8)) begin
      if (wel) begin erase_ok = 1'b1; wip_left = kbusy; end
    end else if (fbits == 16 && op == 8'h05 && !stuck) begin
      if (wip_left > 0) wip_left--;
      if (wip_left == 0) wel = 1'b0;
    end
  end

  // monitors
  int hi_cnt = 0, min_gap = 1000, v_idle = 0, v_mosi = 0, v_per = 0, dcnt = 0, since = 0;
  logic p_sck = 1'b0, p_mosi = 1'b0, per_ok = 1'b0;
  always @(posedge clk) if (cs_n) hi_cnt++; else hi_cnt = 0;
  always @(negedge cs_n) if (rst_n && hi_cnt < min_gap) min_gap = hi_cnt;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sck) v_idle++;
    if (sck && p_sck && mosi != p_mosi) v_mosi++;
    if (cs_n) per_ok = 1'b0;
    else if (sck && !p_sck) begin
      if (per_ok && since != 2*CDIV) v_per++;
      since = 1; per_ok = 1'b1;
    end else since++;
    if (done) dcnt++;
    p_sck = sck; p_mosi = mosi;
  end

  task automatic run(input logic b, input logic [23:0] a, input int k, input logic stk);
    int t, npoll, nexp;
    nfr = 0; erase_ok = 1'b0; wel = 1'b0; wip_left = 0; kbusy = k; stuck = stk; dcnt = 0;
    @(negedge clk); start = 1'b1; bulk = b; addr = a;
    @(negedge clk); start = 1'b0; bulk = !b; addr = ~a;
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk("R5 run finished", t < 20000, 1);
    chk("R5 busy low at done", busy, 0);
    repeat (80) @(negedge clk);
    chk("R5 done one cycle", dcnt, 1);
    npoll = stk ? (TMO + 32*CDIV + GAPC - 1) / (32*CDIV + GAPC) : k + 1;
    nexp = 2 + npoll;
    chk("R9 frame count", nfr, nexp);
    chk("R2 wren bits", f_bits[0], 8);
    chk("R2 wren op", f_op[0], 8'h06);
    chk("R2 wel before erase", erase_ok, 1);
    chk("R3 R10 erase bits", f_bits[1], b ? 8 : 32);
    chk("R3 R10 erase op", f_op[1], b ? 8'hC7 : 8'hD8);
    if (!b) chk("R3 R10 erase addr", f_addr[1], a);
    for (int i = 2; i < nexp && i < 16; i++) begin
      chk("R4 poll bits", f_bits[i], 16);
      chk("R4 poll op", f_op[i], 8'h05);
    end
    chk(stk ? "R8 timeout set" : "R5 R8 timeout clear", timeout, stk);
    chk("R9 idle after run", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 timeout", timeout, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int bb = 0; bb < 2; bb++)
      for (int k = 0; k < 4; k++)
        run(bb[0], 24'h5A0000 ^ (24'h013579 * (k + 1)) ^ {23'h0, bb[0]}, k, 1'b0);
    run(1'b0, 24'hC3A5F0, 0, 1'b1);
    run(1'b1, 24'h000000, 1, 1'b0);
    chk("R6 min cs high", min_gap >= GAPC, 1);
    chk("R7 sck low while deselected", v_idle, 0);
    chk("R7 mosi steady while sck high", v_mosi, 0);
    chk("R7 sck period", v_per, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule